// File: doc/BRIEF.md
# Eight-bit add/subtract unit with flag byte

This block is the arithmetic core of a small eight-bit processor. It takes an accumulator operand, a second operand, an incoming carry bit and a two-bit operation code. It returns the eight-bit result and a flag byte. The four operations are plain add, add with carry, plain subtract and subtract with borrow. The flag byte carries zero, subtract, half-carry and carry in its upper nibble.

The carry-in is never folded into the second operand before the addition. It enters one widened sum, or one widened difference, together with both operands. The carry out of bit 7 is then the top bit of that wide value. The half-carry is bit 4 of the wide value XOR the carry-less sum of the operands. As a result, an operand of 0xFF with carry-in set, or a low nibble of 0xF with carry-in set, still raises the correct carries.

The unit can be built as pure logic. It can also be built with a register stage that captures a result only on an input strobe and holds it otherwise. The parameter `REGISTERED` picks between the two.

Top module: `alu8_flags`

## Requirements
- R1: With op = 0 (ADD), result = (acc + opnd) mod 256, and cin has no effect on result or flags.
- R2: With op = 1 (ADC), result = (acc + opnd + cin) mod 256. For example, acc 0x01, opnd 0xFE, cin 1 gives 0x00 with flag byte 0xB0, and cin 0 gives 0xFF with flag byte 0x00.
- R3: With op = 2 (SUB), result = (acc − opnd) mod 256. With op = 3 (SBC), result = (acc − opnd − cin) mod 256.
- R4: Flag bit 7 (zero) is 1 exactly when the eight-bit result is 0x00.
- R5: Flag bit 6 (subtract) is 0 for op 0 and op 1, and 1 for op 2 and op 3.
- R6: Flag bit 5 (half-carry) is set for an add when the low-nibble sum plus the carry-in used exceeds 0xF. It is set for a subtract when the low nibble of acc is less than the low nibble of opnd plus the borrow-in used.
- R7: Flag bit 4 (carry) is set for an add when acc + opnd + carry-in exceeds 0xFF, including opnd = 0xFF with cin = 1. It is set for a subtract when acc is less than opnd + borrow-in.
- R8: Flag bits 3..0 always read zero.
- R9: With REGISTERED = 1, a cycle with in_valid high loads result and flags at that clock edge and raises out_valid for the following cycle. A cycle with in_valid low clears out_valid and leaves result and flags unchanged.
- R10: While rst_n is low, out_valid, result and flags of the registered variant are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe; loads the output register |
| op | input | 2 | 0 ADD, 1 ADC, 2 SUB, 3 SBC |
| acc | input | W | Accumulator operand |
| opnd | input | W | Second operand |
| cin | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result strobe |
| result | output | W | Arithmetic result |
| flags | output | 8 | {zero, subtract, half-carry, carry, 4'b0} |

## Verification
The assertions assume that op, acc, opnd and cin are settled and known whenever in_valid is high at a clock edge. They also assume that in_valid is held low during reset, so the first strobe they judge comes after reset is released. The bench meets both assumptions: it changes inputs only on the falling clock edge, and it keeps in_valid low through reset. The purely combinational instance is swept between clock edges over every operand pair for each operation, and carry-in takes both values for ADC and SBC.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [1:0]   op,
  input  logic [W-1:0] acc,
  input  logic [W-1:0] opnd,
  input  logic         cin,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic [7:0]   flags
);

  localparam int XW = W + 1;
  localparam int HB = W / 2;

  logic          is_sub;
  logic          cy_used;
  logic [XW-1:0] wide;
  logic          half_bit;
  logic [W-1:0]  next_res;
  logic [7:0]    next_flags;

  assign is_sub  = op[1];
  assign cy_used = op[0] & cin;

  assign wide = is_sub ? ({1'b0, acc} - {1'b0, opnd} - XW'(cy_used))
                       : ({1'b0, acc} + {1'b0, opnd} + XW'(cy_used));

  assign half_bit   = wide[HB] ^ acc[HB] ^ opnd[HB];
  assign next_res   = wide[W-1:0];
  assign next_flags = {next_res == '0, is_sub, half_bit, wide[W], 4'b0000};

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          result    <= '0;
          flags     <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            result <= next_res;
            flags  <= next_flags;
          end
        end
      end

      AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R9
      AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R9
      AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> ($stable(result) && $stable(flags))); // R9
      AST_SUB_FLAG: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> (flags[6] == $past(op[1]))); // R5
      AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> (flags[7] == (result == '0))); // R4
      AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op == 2'd0) |=> (flags[4] == ($past(acc) > ~$past(opnd)))); // R7
      AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op == 2'd2) |=> (flags[4] == ($past(acc) < $past(opnd)))); // R7
    end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = next_res;
      assign flags     = next_flags;

      AST_ZERO_FLAG_C: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> (flags[7] == (result == '0))); // R4
      AST_SUB_FLAG_C: assert property (@(posedge clk) disable iff (!rst_n) in_valid |-> (flags[6] == op[1])); // R5
      AST_ADD_CARRY_C: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op == 2'd0) |-> (flags[4] == (acc > ~opnd))); // R7
      AST_SUB_BORROW_C: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && op == 2'd2) |-> (flags[4] == (acc < opnd))); // R7
    end
  endgenerate

endmodule

// File: tb/alu8_flags_tb_top.sv
module alu8_flags_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5ns clk = ~clk;

  logic       iv_r, iv_c, cin_r, cin_c;
  logic [1:0] op_r, op_c;
  logic [7:0] a_r, b_r, a_c, b_c;
  logic       ov_r, ov_c;
  logic [7:0] res_r, res_c, fl_r, fl_c;

  alu8_flags #(.W(8), .REGISTERED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(iv_r), .op(op_r), .acc(a_r), .opnd(b_r),
    .cin(cin_r), .out_valid(ov_r), .result(res_r), .flags(fl_r));

  alu8_flags #(.W(8), .REGISTERED(1'b0)) dut_comb_i (
    .clk(clk), .rst_n(rst_n), .in_valid(iv_c), .op(op_c), .acc(a_c), .opnd(b_c),
    .cin(cin_c), .out_valid(ov_c), .result(res_c), .flags(fl_c));

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input int op, input int a, input int b, input int c,
                                output int r, output int f);
    int cu, full, lo;
    cu = (op % 2 == 1) ? c : 0;
    if (op < 2) begin
      full = a + b + cu;
      lo   = (a % 16) + (b % 16) + cu;
      f = ((full % 256) == 0 ? 128 : 0) + (lo > 15 ? 32 : 0) + (full > 255 ? 16 : 0);
      r = full % 256;
    end else begin
      full = a - b - cu;
      lo   = (a % 16) - (b % 16) - cu;
      r = (full + 512) % 256;
      f = (r == 0 ? 128 : 0) + 64 + (lo < 0 ? 32 : 0) + (full < 0 ? 16 : 0);
    end
  endfunction

  task automatic reg_op(input int op, input int a, input int b, input int c,
                        input int er, input int ef, input string tag);
    @(negedge clk);
    iv_r = 1'b1; op_r = 2'(op); a_r = 8'(a); b_r = 8'(b); cin_r = c[0];
    @(negedge clk);
    iv_r = 1'b0;
    chk(ov_r == 1'b1, {tag, " R9 out_valid"}, int'(ov_r), 1);
    chk(res_r == 8'(er), {tag, " result"}, int'(res_r), er);
    chk(fl_r == 8'(ef), {tag, " flags"}, int'(fl_r), ef);
  endtask

  initial begin
    #1_500_000ns;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int er, ef;
    iv_r = 0; op_r = 0; a_r = 0; b_r = 0; cin_r = 0;
    iv_c = 0; op_c = 0; a_c = 0; b_c = 0; cin_c = 0;
    repeat (3) @(negedge clk);
    chk(ov_r == 1'b0, "R10 reset out_valid", int'(ov_r), 0);
    chk(res_r == 8'h00, "R10 reset result", int'(res_r), 0);
    chk(fl_r == 8'h00, "R10 reset flags", int'(fl_r), 0);
    rst_n = 1'b1;

    reg_op(1, 8'h01, 8'hFE, 1, 8'h00, 8'hB0, "R2 ADC wrap cin=1");
    reg_op(1, 8'h01, 8'hFE, 0, 8'hFF, 8'h00, "R2 ADC cin=0");
    reg_op(0, 8'h01, 8'hFE, 1, 8'hFF, 8'h00, "R1 ADD ignores cin");
    reg_op(1, 8'h00, 8'hFF, 1, 8'h00, 8'hB0, "R7 ADC FF plus carry");
    reg_op(1, 8'h01, 8'h0F, 1, 8'h11, 8'h20, "R6 ADC nibble F plus carry");
    reg_op(3, 8'h00, 8'hFF, 1, 8'h00, 8'hF0, "R3 SBC wrap");
    reg_op(2, 8'h10, 8'h01, 1, 8'h0F, 8'h60, "R6 SUB half borrow");
    reg_op(2, 8'h42, 8'h42, 0, 8'h00, 8'hC0, "R4 SUB zero");

    @(negedge clk);
    a_r = 8'h77; b_r = 8'h11; op_r = 2'd0; cin_r = 1'b0;
    @(negedge clk);
    chk(ov_r == 1'b0, "R9 no strobe out_valid", int'(ov_r), 0);
    chk(res_r == 8'h00, "R9 hold result", int'(res_r), 0);
    chk(fl_r == 8'hC0, "R9 hold flags", int'(fl_r), 8'hC0);

    iv_c = 1'b1;
    for (int op = 0; op < 4; op++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          for (int c = 0; c < 2; c++) begin
            string tg;
            if (op % 2 == 0 && c == 1) continue;
            op_c = 2'(op); a_c = 8'(a); b_c = 8'(b);
            cin_c = (op % 2 == 0) ? ~a_c[0] : c[0];
            #1ns;
            model(op, a, b, int'(cin_c), er, ef);
            tg = (op == 0) ? "R1" : (op == 1) ? "R2" : "R3";
            chk(res_c == 8'(er), {tg, " sweep result"}, int'(res_c), er);
            chk(fl_c[7] == 1'(ef / 128), "R4 sweep zero", int'(fl_c[7]), ef / 128);
            chk(fl_c[6] == 1'((ef / 64) % 2), "R5 sweep subtract", int'(fl_c[6]), (ef / 64) % 2);
            chk(fl_c[5] == 1'((ef / 32) % 2), "R6 sweep half", int'(fl_c[5]), (ef / 32) % 2);
            chk(fl_c[4] == 1'((ef / 16) % 2), "R7 sweep carry", int'(fl_c[4]), (ef / 16) % 2);
            chk(fl_c[3:0] == 4'h0, "R8 sweep low nibble", int'(fl_c[3:0]), 0);
          end
        end
      end
    end
    iv_c = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule